// File: doc/BRIEF.md
# Coherence Response Completion Tracker

This block keeps count of the responses owed to several coherence transactions that are open at the same time: multicast updates, multicast invalidations and broadcast invalidations. A controller that is about to launch such a transaction asks the block for a free slot. The index of that slot becomes the transaction ID carried by every request packet. When the controller launches the transaction, it also loads the number of responses it expects. For a broadcast invalidation, that number is the count of copies held. Only holders answer, and a cache that holds the line twice answers twice.

Each response is a single flit that returns the transaction ID. The block counts one response against the matching slot. When the last expected response arrives, the block raises that slot's bit in a completion vector for one cycle and frees the slot at the same time. The owning controller uses this completion to release the acknowledgement of the write that started the transaction. A response that names no open slot is reported on an error flag and has no other effect.

Top module: `coh_done_tracker`

## Requirements
- R1: After reset, no slot is open, `alloc_full` is 0, `alloc_id` is 0, and `done_vec` and `rsp_err` are 0.
- R2: `alloc_id` always shows the lowest-numbered free slot. A launch (`alloc_req`=1 while `alloc_full`=0) opens that slot with `alloc_count` expected responses.
- R3: `alloc_full` is 1 exactly when all DEPTH slots are open. A launch request while full is ignored and changes no slot.
- R4: Each response (`rsp_valid`=1) whose `rsp_id` names an open slot lowers that slot's remaining count by one. When it reaches zero, bit `rsp_id` of `done_vec` is 1 for exactly the one cycle after the clock edge that took the final response.
- R5: A slot is free in the same cycle that its `done_vec` bit is high, and it can be granted again in that cycle.
- R6: Responses to different open slots may arrive in any interleaving. Each slot counts only responses that carry its own ID.
- R7: A response whose ID names a free slot, or is not below DEPTH, drives `rsp_err` high for one cycle after the edge and changes no count.
- R8: A launch with `alloc_count`=0 completes at once. Its `done_vec` bit is high in the next cycle, and the slot stays free.
- R9: When a launch and a response target the same slot in one cycle, the launch wins. The response is treated as stray (R7) and does not reduce the newly loaded count.
- R10: Completions of several slots in the same cycle all appear together in `done_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Launch a transaction into the slot shown on `alloc_id` |
| alloc_count | input | CNT_W | Number of responses the launch expects |
| alloc_id | output | IDX_W | Lowest free slot, used as the transaction ID |
| alloc_full | output | 1 | All slots open; launches are ignored |
| rsp_valid | input | 1 | A response flit is present |
| rsp_id | input | IDX_W | Transaction ID returned by the response |
| done_vec | output | DEPTH | One-cycle completion bit per slot |
| rsp_err | output | 1 | One-cycle flag for a response with no open slot |

## Verification
The launch path and the response path can act in the same cycle. The bench provokes three cases of this:
- a launch and a response aimed at the same free slot;
- a launch into a slot in the very cycle that the slot reports completion;
- a zero-count launch while another slot takes its final response.

The scoreboard predicts each of these from the pre-edge state of the slots. It then expects the exact `done_vec` mask, the `rsp_err` pulse, and the later response counts of the newly opened slot.

// File: rtl/coh_trk_pkg.sv
package coh_trk_pkg;

    // What one slot does in a cycle
    typedef enum logic [1:0] {
        SLOT_HOLD = 2'd0,
        SLOT_LOAD = 2'd1,
        SLOT_STEP = 2'd2,
        SLOT_LAST = 2'd3
    } slot_op_e;

endpackage

// File: rtl/coh_trk_pick.sv
module coh_trk_pick #(
    parameter int DEPTH = 4,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] busy,
    output logic [IDX_W-1:0] idx,
    output logic             full
);

    // Scan downward so the lowest free slot is written last and wins.
    always_comb begin
        idx  = '0;
        full = 1'b1;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                idx  = IDX_W'(i);
                full = 1'b0;
            end
        end
    end

endmodule

// File: rtl/coh_trk_slot.sv
module coh_trk_slot
    import coh_trk_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             busy_q,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             grant,
    input  logic [CNT_W-1:0] load,
    input  logic             hit,
    output logic             busy_d,
    output logic [CNT_W-1:0] cnt_d,
    output logic             done_d,
    output slot_op_e         op
);

    always_comb begin
        // Pick the action first: a grant wins over a response.
        if (grant)                                  op = SLOT_LOAD;
        else if (hit && busy_q && cnt_q == CNT_W'(1)) op = SLOT_LAST;
        else if (hit && busy_q)                     op = SLOT_STEP;
        else                                        op = SLOT_HOLD;

        busy_d = busy_q;
        cnt_d  = cnt_q;
        done_d = 1'b0;

        unique case (op)
            SLOT_LOAD: begin
                busy_d = (load != '0);
                cnt_d  = load;
                done_d = (load == '0);
            end
            SLOT_STEP: cnt_d = cnt_q - CNT_W'(1);
            SLOT_LAST: begin
                busy_d = 1'b0;
                cnt_d  = '0;
                done_d = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/coh_done_tracker.sv
module coh_done_tracker
    import coh_trk_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic [CNT_W-1:0] alloc_count,
    output logic [IDX_W-1:0] alloc_id,
    output logic             alloc_full,
    input  logic             rsp_valid,
    input  logic [IDX_W-1:0] rsp_id,
    output logic [DEPTH-1:0] done_vec,
    output logic             rsp_err
);

    typedef struct packed {
        logic [DEPTH-1:0]            busy;
        logic [DEPTH-1:0][CNT_W-1:0] cnt;
        logic [DEPTH-1:0]            done;
        logic                        err;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic [DEPTH-1:0]            slot_busy_d;
    logic [DEPTH-1:0][CNT_W-1:0] slot_cnt_d;
    logic [DEPTH-1:0]            slot_done_d;
    slot_op_e                    slot_op [DEPTH];
    logic                        launch;
    logic                        stray;

    coh_trk_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_pick (
        .busy (st_q.busy),
        .idx  (alloc_id),
        .full (alloc_full)
    );

    assign launch = alloc_req && !alloc_full;

    // One slot instance per table entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        coh_trk_slot #(.CNT_W(CNT_W)) i_slot (
            .busy_q (st_q.busy[g]),
            .cnt_q  (st_q.cnt[g]),
            .grant  (launch && alloc_id == IDX_W'(g)),
            .load   (alloc_count),
            .hit    (rsp_valid && rsp_id == IDX_W'(g)),
            .busy_d (slot_busy_d[g]),
            .cnt_d  (slot_cnt_d[g]),
            .done_d (slot_done_d[g]),
            .op     (slot_op[g])
        );
    end

    always_comb begin
        // The granted slot was free before the edge, so a response to it is stray too.
        stray = 1'b0;
        if (rsp_valid) begin
            if (int'(rsp_id) >= DEPTH) stray = 1'b1;
            else                       stray = !st_q.busy[rsp_id];
        end
        st_d      = st_q;
        st_d.busy = slot_busy_d;
        st_d.cnt  = slot_cnt_d;
        st_d.done = slot_done_d;
        st_d.err  = stray;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_vec = st_q.done;
    assign rsp_err  = st_q.err;

    // ---------------- assertions ----------------
    assert_full_all_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_full |-> (&st_q.busy));

    assert_err_after_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $past(rsp_valid));

    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        assert_launch_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_req && !alloc_full && alloc_id == IDX_W'(g) && alloc_count != '0)
            |=> (st_q.busy[g] && !done_vec[g]));

        assert_zero_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_req && !alloc_full && alloc_id == IDX_W'(g) && alloc_count == '0)
            |=> (done_vec[g] && !st_q.busy[g]));

        assert_open_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.busy[g] |-> (st_q.cnt[g] != '0));

        assert_free_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
            done_vec[g] |-> !st_q.busy[g]);

        assert_other_id_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.busy[g] && !(rsp_valid && rsp_id == IDX_W'(g)))
            |=> (st_q.busy[g] && $stable(st_q.cnt[g])));

        assert_stray_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && rsp_id == IDX_W'(g) && !st_q.busy[g]) |=> rsp_err);
    end

endmodule

// File: tb/test_coh_done_tracker.sv
module test_coh_done_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int CNT_W = 4;
    localparam int IDX_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_req = 1'b0;
    logic [CNT_W-1:0] alloc_count = '0;
    logic [IDX_W-1:0] alloc_id;
    logic             alloc_full;
    logic             rsp_valid = 1'b0;
    logic [IDX_W-1:0] rsp_id = '0;
    logic [DEPTH-1:0] done_vec;
    logic             rsp_err;

    coh_done_tracker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_coh_done_tracker (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_count(alloc_count),
        .alloc_id(alloc_id), .alloc_full(alloc_full), .rsp_valid(rsp_valid),
        .rsp_id(rsp_id), .done_vec(done_vec), .rsp_err(rsp_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int when; int id; } exp_t;
    exp_t dq[$];
    int   eq[$];
    bit   mbusy[DEPTH];
    int   mrem[DEPTH];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   mon_on = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Scoreboard monitor: compares outputs against pushed expectations
    always @(negedge clk) begin
        if (mon_on) begin
            logic [DEPTH-1:0] m;
            bit e;
            m = '0;
            e = 1'b0;
            for (int k = dq.size() - 1; k >= 0; k--) begin
                if (dq[k].when == cyc) begin
                    m[dq[k].id] = 1'b1;
                    dq.delete(k);
                end else if (dq[k].when < cyc) begin
                    check(1'b0, "R4 overdue completion", dq[k].id, -1);
                    dq.delete(k);
                end
            end
            for (int k = eq.size() - 1; k >= 0; k--) begin
                if (eq[k] == cyc) begin
                    e = 1'b1;
                    eq.delete(k);
                end
            end
            check(done_vec == m, "R4/R10 done_vec", int'(done_vec), int'(m));
            check(rsp_err == e, "R7 rsp_err", int'(rsp_err), int'(e));
        end
    end

    // Driver: drives one cycle, predicts from the pre-edge model state
    task automatic step(input bit a, input int cnt, input bit r, input int rid, input string tag);
        int  gid;
        bit  full;
        full = 1'b1;
        gid  = 0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!mbusy[i]) begin
                gid  = i;
                full = 1'b0;
            end
        end
        alloc_req   = a;
        alloc_count = CNT_W'(cnt);
        rsp_valid   = r;
        rsp_id      = IDX_W'(rid);
        #1;
        check(alloc_full == full, {"R3 full ", tag}, int'(alloc_full), int'(full));
        if (!full) check(alloc_id == IDX_W'(gid), {"R2 alloc_id ", tag}, int'(alloc_id), gid);
        if (r) begin
            if (rid < DEPTH && mbusy[rid]) begin
                mrem[rid]--;
                if (mrem[rid] == 0) begin
                    mbusy[rid] = 1'b0;
                    dq.push_back('{cyc + 1, rid});
                end
            end else begin
                eq.push_back(cyc + 1);
            end
        end
        if (a && !full) begin
            if (cnt == 0) dq.push_back('{cyc + 1, gid});
            else begin
                mbusy[gid] = 1'b1;
                mrem[gid]  = cnt;
            end
        end
        @(negedge clk);
        alloc_req = 1'b0;
        rsp_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        check(1'b0, "watchdog expired", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(alloc_full == 1'b0, "R1 full", int'(alloc_full), 0);
        check(alloc_id == '0, "R1 alloc_id", int'(alloc_id), 0);
        check(done_vec == '0, "R1 done_vec", int'(done_vec), 0);
        check(rsp_err == 1'b0, "R1 rsp_err", int'(rsp_err), 0);
        mon_on = 1'b1;
        @(negedge clk);

        step(1, 3, 0, 0, "R2 open slot0");
        step(1, 2, 0, 0, "R2 open slot1");
        step(1, 1, 0, 0, "R2 open slot2");
        step(1, 2, 0, 0, "R2 open slot3");
        step(1, 5, 0, 0, "R3 launch while full ignored");
        step(0, 0, 1, 2, "R4 final response slot2");
        step(1, 2, 1, 2, "R9 launch and response same slot");
        step(0, 0, 1, 1, "R6 slot1 step");
        step(0, 0, 1, 0, "R6 slot0 step");
        step(0, 0, 1, 0, "R6 slot0 step");
        step(0, 0, 1, 0, "R4 slot0 final");
        step(1, 0, 1, 1, "R5 R8 R10 zero launch into freed slot0 with slot1 final");
        step(0, 0, 1, 0, "R7 stray to free slot0");
        step(0, 0, 1, 3, "R6 interleave slot3");
        step(0, 0, 1, 2, "R6 interleave slot2");
        step(0, 0, 1, 3, "R6 slot3 final");
        step(0, 0, 1, 2, "R9 slot2 final after two");
        step(0, 0, 1, 3, "R7 stray to freed slot3");
        step(0, 0, 0, 0, "idle");
        step(0, 0, 0, 0, "idle");
        step(0, 0, 0, 0, "idle");

        check(dq.size() == 0, "R4 pending completions", dq.size(), 0);
        check(eq.size() == 0, "R7 pending errors", eq.size(), 0);
        check(alloc_id == '0 && !alloc_full, "R5 all slots free", int'(alloc_id), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule